// File: doc/BRIEF.md
# Flash Region Write Guard

This block holds the setting that fences off the top end of a 64 KB flash address space against programming and erasing. The fenced area always ends at the highest address and starts on a 512-byte page boundary. The setting is an 8-bit value: a 7-bit page selector and a single open flag. At reset it is taken from a value presented by the nonvolatile store.

While protection is active, application software may only move the fence downward, which grows the fenced area. Any software write that would shrink or remove it is dropped without notice. A separate debug write path loads any value at all, so a protected device can still be reopened for reprogramming.

The command sequencer presents every program or erase request to the block. In the same cycle the block answers whether the request must be refused as a protection violation.

Top module: `flash_region_guard`

## Requirements
- R1: On a clock edge with `rst_n` low, the stored setting `prot_value` is loaded from `nv_image`.
- R2: Bit 0 of `prot_value` is the open flag (1 = nothing is protected) and bits 7:1 are the page selector. `last_open_addr` equals the selector followed by nine 1 bits (selector 0x7C gives 0xF9FF). Every address above it, up to 0xFFFF, is protected.
- R3: While the open flag is 1, a software write (`sw_wr_en`) stores `sw_wr_data` unchanged on the next edge.
- R4: While the open flag is 0, a software write is stored only if its open flag is 0 and its selector is less than or equal to the current selector. Any other software write leaves `prot_value` unchanged.
- R5: A debug write (`dbg_wr_en`) stores `dbg_wr_data` unconditionally on the next edge. If a software write arrives in the same cycle, the debug write wins.
- R6: For a request with `req_kind` 2'b00 (byte program), 2'b01 (page erase) or 2'b11 (burst program), `req_violation` is 1 in the same cycle exactly when `req_valid` is 1, the open flag is 0, and `req_addr` is greater than `last_open_addr`.
- R7: For a request with `req_kind` 2'b10 (whole-array erase), `req_violation` is 1 exactly when `req_valid` is 1 and the open flag is 0.
- R8: With `req_valid` low, `req_violation` is 0.
- R9: With neither write enable asserted, `prot_value` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nv_image | input | 8 | Setting held by the nonvolatile store, loaded at reset |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | 8 | Software write value |
| dbg_wr_en | input | 1 | Debug write strobe |
| dbg_wr_data | input | 8 | Debug write value |
| req_valid | input | 1 | A program or erase request is present |
| req_kind | input | 2 | Request type: 00 byte program, 01 page erase, 10 whole-array erase, 11 burst program |
| req_addr | input | 16 | Target address of the request |
| prot_value | output | 8 | Current setting: selector in bits 7:1, open flag in bit 0 |
| last_open_addr | output | 16 | Highest address that is not protected |
| req_violation | output | 1 | Request targets protected flash |

## Verification
Requests are placed on both sides of the fence: exactly at `last_open_addr`, one byte above it, at 0x0000 and at 0xFFFF. This separates an off-by-one boundary from a correct one. Each request pattern is tried again with the open flag set, to show that an open device refuses nothing. Software writes cover a smaller selector, an equal selector, a larger selector and an attempt to set the open flag, which separates a growing fence from a shrinking one. A debug write that collides with a software write shows which path has priority, and a repeated reset shows the nonvolatile value being reloaded.

// File: rtl/fprot_pkg.sv
// Package: shared request encoding for the flash region guard.
// Assumes: requests are classified by a 2-bit kind code driven by the sequencer.
package fprot_pkg;

    typedef enum logic [1:0] {
        REQ_BYTE_PROG  = 2'b00,
        REQ_PAGE_ERASE = 2'b01,
        REQ_MASS_ERASE = 2'b10,
        REQ_BURST_PROG = 2'b11
    } req_kind_e;

endpackage

// File: rtl/fprot_write_filter.sv
// Module: fprot_write_filter
// Decides whether a write may update the protection setting and which value it carries.
// The debug path always wins. A software write passes if the region is open, or if it
// keeps protection active and does not raise the selector (does not shrink the fenced area).
// Assumes: the setting is {selector, open_flag}, with the open flag in the LSB.
module fprot_write_filter #(
    parameter int unsigned SEL_W = 7,
    localparam int unsigned REG_W = SEL_W + 1
) (
    input  logic [REG_W-1:0] cur_value,
    input  logic             sw_en,
    input  logic [REG_W-1:0] sw_data,
    input  logic             dbg_en,
    input  logic [REG_W-1:0] dbg_data,
    output logic             load,
    output logic [REG_W-1:0] next_value
);

    logic             cur_open;
    logic [SEL_W-1:0] cur_sel;
    logic             new_open;
    logic [SEL_W-1:0] new_sel;
    logic             sw_grows;
    logic             sw_ok;

    // Split the current and proposed settings into their fields.
    always_comb begin
        cur_open = cur_value[0];
        cur_sel  = cur_value[REG_W-1:1];
        new_open = sw_data[0];
        new_sel  = sw_data[REG_W-1:1];
    end

    // Software write rule: anything goes when open, otherwise only an equal or lower selector.
    always_comb begin
        sw_grows = !new_open && (new_sel <= cur_sel);
        sw_ok    = sw_en && (cur_open || sw_grows);
    end

    // Choose the winning source; debug has priority over software.
    always_comb begin
        load       = dbg_en || sw_ok;
        next_value = dbg_en ? dbg_data : sw_data;
    end

endmodule

// File: rtl/fprot_region_check.sv
// Module: fprot_region_check
// Combinational violation check for program and erase requests.
// Address-based kinds compare against the last open address. A whole-array erase is
// refused whenever any protection is active.
// Assumes: the fenced region runs from just above the last open address to the top of memory.
module fprot_region_check
    import fprot_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned PAGE_BITS = 9,
    localparam int unsigned SEL_W    = ADDR_W - PAGE_BITS
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic              open_flag,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [ADDR_W-1:0] last_open,
    output logic              violation
);

    req_kind_e kind;
    logic      above_fence;

    // Build the boundary address: selector in the upper bits, all-ones page offset.
    always_comb begin
        last_open = {sel, {PAGE_BITS{1'b1}}};
    end

    // Decode the request kind and compare the address with the boundary.
    always_comb begin
        kind        = req_kind_e'(req_kind);
        above_fence = req_addr > last_open;
    end

    // Flag a violation only for a valid request while protection is active.
    always_comb begin
        violation = 1'b0;
        if (req_valid && !open_flag) begin
            if (kind == REQ_MASS_ERASE) begin
                violation = 1'b1;
            end else begin
                violation = above_fence;
            end
        end
    end

endmodule

// File: rtl/flash_region_guard.sv
// Module: flash_region_guard (top)
// Holds the flash protection setting, loads it from the nonvolatile image during reset,
// filters writes, and reports protection violations for program and erase requests.
// Assumes: synchronous active-low reset held for at least one edge; nv_image is stable
// while reset is asserted.
module flash_region_guard #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned PAGE_BITS = 9,
    localparam int unsigned SEL_W    = ADDR_W - PAGE_BITS,
    localparam int unsigned REG_W    = SEL_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  nv_image,
    input  logic              sw_wr_en,
    input  logic [REG_W-1:0]  sw_wr_data,
    input  logic              dbg_wr_en,
    input  logic [REG_W-1:0]  dbg_wr_data,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [REG_W-1:0]  prot_value,
    output logic [ADDR_W-1:0] last_open_addr,
    output logic              req_violation
);

    logic [REG_W-1:0] prot_q;
    logic             wr_load;
    logic [REG_W-1:0] wr_value;

    // Write gating: decides whether and what to store this cycle.
    fprot_write_filter #(
        .SEL_W (SEL_W)
    ) i_filter (
        .cur_value  (prot_q),
        .sw_en      (sw_wr_en),
        .sw_data    (sw_wr_data),
        .dbg_en     (dbg_wr_en),
        .dbg_data   (dbg_wr_data),
        .load       (wr_load),
        .next_value (wr_value)
    );

    // Setting register: reload from the nonvolatile image in reset, else take accepted writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_q <= nv_image;
        end else if (wr_load) begin
            prot_q <= wr_value;
        end
    end

    // Request check against the stored setting.
    fprot_region_check #(
        .ADDR_W    (ADDR_W),
        .PAGE_BITS (PAGE_BITS)
    ) i_check (
        .sel       (prot_q[REG_W-1:1]),
        .open_flag (prot_q[0]),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .last_open (last_open_addr),
        .violation (req_violation)
    );

    // Expose the stored setting.
    always_comb begin
        prot_value = prot_q;
    end

endmodule

// File: rtl/fprot_guard_checker.sv
// Module: fprot_guard_checker
// Assertions on the flash region guard, attached to every instance through bind.
// Assumes: the same parameters as the guard it is bound to.
module fprot_guard_checker #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned PAGE_BITS = 9,
    localparam int unsigned SEL_W    = ADDR_W - PAGE_BITS,
    localparam int unsigned REG_W    = SEL_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [REG_W-1:0]  nv_image,
    input logic              sw_wr_en,
    input logic [REG_W-1:0]  sw_wr_data,
    input logic              dbg_wr_en,
    input logic [REG_W-1:0]  dbg_wr_data,
    input logic              req_valid,
    input logic [1:0]        req_kind,
    input logic [ADDR_W-1:0] req_addr,
    input logic [REG_W-1:0]  prot_value,
    input logic              req_violation
);

    // R1: a reset edge loads the nonvolatile image.
    a_r1_reset_load: assert property (@(posedge clk)
        !rst_n |=> prot_value == $past(nv_image));

    // R3: an open setting accepts any software write.
    a_r3_open_write: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr_en && !dbg_wr_en && prot_value[0]) |=> prot_value == $past(sw_wr_data));

    // R4: a write that would shrink or remove protection is dropped.
    a_r4_no_shrink: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr_en && !dbg_wr_en && !prot_value[0] &&
         (sw_wr_data[0] || sw_wr_data[REG_W-1:1] > prot_value[REG_W-1:1]))
        |=> $stable(prot_value));

    // R5: a debug write always lands.
    a_r5_debug_write: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_wr_en |=> prot_value == $past(dbg_wr_data));

    // R6: address-checked requests are refused exactly above the fence.
    a_r6_addr_check: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind != 2'b10) |->
        req_violation == (!prot_value[0] &&
                          req_addr > {prot_value[REG_W-1:1], {PAGE_BITS{1'b1}}}));

    // R7: a whole-array erase is refused whenever protection is active.
    a_r7_mass_erase: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'b10) |-> req_violation == !prot_value[0]);

    // R8: no request, no violation.
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !req_violation);

    // R9: the setting holds when nothing writes it.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr_en && !dbg_wr_en) |=> $stable(prot_value));

endmodule

bind flash_region_guard fprot_guard_checker #(
    .ADDR_W    (ADDR_W),
    .PAGE_BITS (PAGE_BITS)
) i_guard_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .nv_image      (nv_image),
    .sw_wr_en      (sw_wr_en),
    .sw_wr_data    (sw_wr_data),
    .dbg_wr_en     (dbg_wr_en),
    .dbg_wr_data   (dbg_wr_data),
    .req_valid     (req_valid),
    .req_kind      (req_kind),
    .req_addr      (req_addr),
    .prot_value    (prot_value),
    .req_violation (req_violation)
);

// File: tb/test_flash_region_guard.sv
module test_flash_region_guard;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  nv_image;
    logic        sw_wr_en;
    logic [7:0]  sw_wr_data;
    logic        dbg_wr_en;
    logic [7:0]  dbg_wr_data;
    logic        req_valid;
    logic [1:0]  req_kind;
    logic [15:0] req_addr;
    logic [7:0]  prot_value;
    logic [15:0] last_open_addr;
    logic        req_violation;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    int model_reg = 0;

    always #2.5 clk = ~clk;

    flash_region_guard i_flash_region_guard (
        .clk            (clk),
        .rst_n          (rst_n),
        .nv_image       (nv_image),
        .sw_wr_en       (sw_wr_en),
        .sw_wr_data     (sw_wr_data),
        .dbg_wr_en      (dbg_wr_en),
        .dbg_wr_data    (dbg_wr_data),
        .req_valid      (req_valid),
        .req_kind       (req_kind),
        .req_addr       (req_addr),
        .prot_value     (prot_value),
        .last_open_addr (last_open_addr),
        .req_violation  (req_violation)
    );

    // Behavioural reference of the stored setting (R1, R3, R4, R5, R9).
    always @(posedge clk) begin
        if (!rst_n) begin
            model_reg <= int'(nv_image);
        end else if (dbg_wr_en) begin
            model_reg <= int'(dbg_wr_data);
        end else if (sw_wr_en) begin
            if (model_reg % 2 == 1) begin
                model_reg <= int'(sw_wr_data);
            end else if (sw_wr_data[0] == 1'b0 && int'(sw_wr_data) / 2 <= model_reg / 2) begin
                model_reg <= int'(sw_wr_data);
            end
        end
    end

    function automatic int model_limit();
        return (model_reg / 2) * 512 + 511;
    endfunction

    function automatic bit model_violation();
        if (!req_valid) return 1'b0;
        if (model_reg % 2 == 1) return 1'b0;
        if (req_kind == 2'b10) return 1'b1;
        return int'(req_addr) > model_limit();
    endfunction

    task automatic check(input string tag, input int actual, input int expected);
        total++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, actual, expected, $time);
        end
    endtask

    // Drive one cycle of stimulus, then compare every output with the model.
    task automatic step(input bit rn, input bit sw, input logic [7:0] swd,
                        input bit dbg, input logic [7:0] dbgd,
                        input bit rv, input logic [1:0] rk, input logic [15:0] ra,
                        input string tag);
        @(negedge clk);
        rst_n       = rn;
        sw_wr_en    = sw;
        sw_wr_data  = swd;
        dbg_wr_en   = dbg;
        dbg_wr_data = dbgd;
        req_valid   = rv;
        req_kind    = rk;
        req_addr    = ra;
        #1;
        if (rst_n) begin
            check({tag, " R2 setting"}, int'(prot_value), model_reg);
            check({tag, " R2 boundary"}, int'(last_open_addr), model_limit());
            check({tag, " violation"}, int'(req_violation), int'(model_violation()));
        end
    endtask

    task automatic req(input logic [1:0] rk, input logic [15:0] ra, input string tag);
        step(1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, rk, ra, tag);
    endtask

    task automatic swr(input logic [7:0] d, input string tag);
        step(1'b1, 1'b1, d, 1'b0, 8'h00, 1'b0, 2'b00, 16'h0000, tag);
    endtask

    task automatic idle(input string tag);
        step(1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 2'b00, 16'hFFFF, tag);
    endtask

    initial begin
        rst_n = 1'b0; nv_image = 8'hF8; sw_wr_en = 1'b0; sw_wr_data = 8'h00;
        dbg_wr_en = 1'b0; dbg_wr_data = 8'h00; req_valid = 1'b0;
        req_kind = 2'b00; req_addr = 16'h0000;
        step(1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 2'b00, 16'h0000, "reset");
        step(1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 2'b00, 16'h0000, "reset");
        idle("R1 reset load");
        check("R1 F8 image", int'(prot_value), 8'hF8);
        check("R2 F9FF boundary", int'(last_open_addr), 16'hF9FF);
        // R6 around the fence, R7, R8
        req(2'b00, 16'hF9FF, "R6 last open");
        req(2'b00, 16'hFA00, "R6 first fenced");
        check("R6 FA00 refused", int'(req_violation), 1);
        req(2'b01, 16'hFFFF, "R6 page erase top");
        req(2'b11, 16'h0000, "R6 burst bottom");
        req(2'b10, 16'h1234, "R7 mass erase protected");
        check("R7 mass refused", int'(req_violation), 1);
        idle("R8 idle top address");
        check("R8 idle quiet", int'(req_violation), 0);
        // R4 shrinking attempts
        swr(8'hF9, "R4 set open flag");
        idle("R4 after open attempt");
        swr(8'hFA, "R4 raise selector");
        idle("R4 after raise");
        check("R4 unchanged", int'(prot_value), 8'hF8);
        swr(8'hF8, "R4 equal selector");
        swr(8'hF0, "R4 lower selector");
        idle("R4 grown");
        check("R4 grown to F0", int'(prot_value), 8'hF0);
        req(2'b00, 16'hF1FF, "R6 new last open");
        req(2'b00, 16'hF200, "R6 new first fenced");
        // R9 hold over several cycles
        idle("R9 hold 1");
        idle("R9 hold 2");
        // R5 debug opens everything
        step(1'b1, 1'b0, 8'h00, 1'b1, 8'hFF, 1'b0, 2'b00, 16'h0000, "R5 debug open");
        req(2'b00, 16'hFFFF, "R6 open top");
        check("R6 open no refusal", int'(req_violation), 0);
        req(2'b10, 16'h0000, "R7 mass open");
        // R3 open accepts any value
        swr(8'h10, "R3 open write");
        idle("R3 after write");
        check("R3 stored 10", int'(prot_value), 8'h10);
        swr(8'h20, "R4 raise from 10");
        req(2'b01, 16'h1200, "R6 fenced at 1200");
        // R5 debug beats software in the same cycle
        step(1'b1, 1'b1, 8'h02, 1'b1, 8'h7F, 1'b0, 2'b00, 16'h0000, "R5 collision");
        idle("R5 after collision");
        check("R5 debug wins", int'(prot_value), 8'h7F);
        // R3 then R4 down to selector zero
        swr(8'h00, "R3 write zero");
        req(2'b00, 16'h01FF, "R6 zero last open");
        req(2'b00, 16'h0200, "R6 zero fenced");
        // R1 reload with an open image
        nv_image = 8'hFF;
        step(1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 2'b00, 16'h0000, "reset2");
        idle("R1 reload");
        check("R1 FF image", int'(prot_value), 8'hFF);
        req(2'b10, 16'h0000, "R7 open after reload");
        idle("end");
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule